// File: doc/BRIEF.md
# Cascadable Serial Multichannel DAC Code Loader

This block is the digital front end of a bank of 6-bit digital-to-analogue converters that are programmed over a three-wire serial link. A slow serial clock, a serial data line and an active-low load strobe arrive from outside and are sampled by the fast system clock. While the strobe is low, each falling edge of the serial clock moves one bit into a shift chain made of one 6-bit word stage per channel. When the strobe returns high, every stage is copied in the same cycle into the per-channel code registers that drive the converters.

Words are sent most significant bit first. The word sent last ends up in channel 1, the one before it in channel 2, and so on. A host that sends only k words therefore updates channels 1 to k, while the higher channels receive older words that have moved up the chain. The far end of the chain leaves the block as a serial output, so several devices can be chained by feeding this output into the next device's data input. A code of 0 selects the lowest analogue level and 63 the highest. The converter network itself is not part of this block.

Top module: `serdac_loader`

## Requirements
- R1: Each channel code is 6 bits, sent most significant bit first; the first bit of a word lands in bit 5 of that channel's code and the last bit in bit 0.
- R2: The chain moves one bit only on a high-to-low transition of the serial clock while the strobe is low; low-to-high transitions of the serial clock do not move it.
- R3: While the load strobe is high, serial clock edges leave the chain and the codes unchanged.
- R4: On a low-to-high transition of the load strobe, all channel codes are updated together from the chain in one system cycle; at all other times the codes hold.
- R5: After a full load of 6·N bits, the word sent last is in channel 1 (codes bits 5:0), and channel c (codes bits 6c-1:6c-6) holds the word sent c-1 words before the last one.
- R6: A load of only k < N words updates channels 1 to k with those words; channel j > k receives the word that was in chain position j-k before the load.
- R7: The serial output is the bit at the far end of the chain, so a bit sent into the data input reappears at the serial output after 6·N falling clock edges.
- R8: A synchronous reset clears the chain and every channel code to zero and drives the serial output low.
- R9: A serial clock falling edge that is sampled in the same cycle as the strobe rising edge does not move the chain, so the transferred codes are those from before that edge.
- R10: Every code value from 0 to 63 is carried unaltered into each channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk | input | 1 | Serial clock; falling edges move the chain |
| ser_din | input | 1 | Serial data input |
| load_n | input | 1 | Load strobe, active low; rising edge transfers the chain to the codes |
| ser_dout | output | 1 | Far end of the shift chain, for cascading |
| codes | output | 6·CHANNELS | Channel codes; channel c at bits 6c-1:6c-6 |

## Verification
A chain that moves on the wrong clock edge or while the strobe is high shows up at the serial output within one bit period, long before any transfer, because that output is compared with an arithmetic model after every bit. A wrong word order, a bit reversal inside a word or a stale code register shows at the code outputs a few system cycles after the strobe rises, since every channel is compared after every load. The sweep sends all 64 values to every channel, adds a partial load, an edge that coincides with the strobe release and a reset during a load.

// File: rtl/serdac_loader.sv
module serdac_loader #(
  parameter int CHANNELS    = 4,
  parameter int CODE_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         ser_clk,
  input  logic                         ser_din,
  input  logic                         load_n,
  output logic                         ser_dout,
  output logic [CHANNELS*CODE_W-1:0]   codes
);

  localparam int CHAIN_W = CHANNELS * CODE_W;

  logic [SYNC_STAGES-1:0] sck_sy, din_sy, ld_sy;
  logic                   sck_prev, ld_prev;
  logic [CHAIN_W-1:0]     chain;

  logic sck_s, din_s, ld_s;
  logic sck_fall, ld_rise, shift_en;

  assign sck_s = sck_sy[SYNC_STAGES-1];
  assign din_s = din_sy[SYNC_STAGES-1];
  assign ld_s  = ld_sy[SYNC_STAGES-1];

  assign sck_fall = sck_prev & ~sck_s;
  assign ld_rise  = ~ld_prev & ld_s;
  assign shift_en = sck_fall & ~ld_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_sy   <= '0;
      din_sy   <= '0;
      ld_sy    <= '1;
      sck_prev <= 1'b0;
      ld_prev  <= 1'b1;
    end else begin
      sck_sy   <= {sck_sy[SYNC_STAGES-2:0], ser_clk};
      din_sy   <= {din_sy[SYNC_STAGES-2:0], ser_din};
      ld_sy    <= {ld_sy[SYNC_STAGES-2:0], load_n};
      sck_prev <= sck_s;
      ld_prev  <= ld_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      chain <= '0;
    else if (shift_en)
      chain <= {chain[CHAIN_W-2:0], din_s};
  end

  always_ff @(posedge clk) begin
    if (rst)
      codes <= '0;
    else if (ld_rise)
      codes <= chain;
  end

  assign ser_dout = chain[CHAIN_W-1];

endmodule

module serdac_loader_chk #(
  parameter int CHAIN_W = 24
) (
  input logic               clk,
  input logic               rst,
  input logic               ld_s,
  input logic               ld_rise,
  input logic               shift_en,
  input logic [CHAIN_W-1:0] chain,
  input logic [CHAIN_W-1:0] codes
);

  a_r4_codes_hold: assert property (@(posedge clk) disable iff (rst)
    !ld_rise |=> $stable(codes));

  a_r4_transfer_all: assert property (@(posedge clk) disable iff (rst)
    ld_rise |=> codes == $past(chain));

  a_r3_frozen_when_high: assert property (@(posedge clk) disable iff (rst)
    ld_s |=> $stable(chain));

  a_r2_idle_no_shift: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(chain));

  a_r9_release_no_shift: assert property (@(posedge clk) disable iff (rst)
    ld_rise |=> $stable(chain));

endmodule

bind serdac_loader serdac_loader_chk #(.CHAIN_W(CHANNELS*CODE_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ld_s     (ld_s),
  .ld_rise  (ld_rise),
  .shift_en (shift_en),
  .chain    (chain),
  .codes    (codes)
);

// File: tb/test_serdac_loader.sv
module test_serdac_loader;
  localparam int N  = 4;
  localparam int W  = 6;
  localparam int L  = N * W;
  localparam int PH = 4;

  logic clk = 1'b0, rst = 1'b1, ser_clk = 1'b0, ser_din = 1'b0, load_n = 1'b1;
  logic ser_dout;
  logic [L-1:0] codes;
  logic [L-1:0] m_chain = '0;
  logic [L-1:0] m_codes = '0;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  serdac_loader #(.CHANNELS(N), .CODE_W(W)) i_serdac_loader (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_din(ser_din),
    .load_n(load_n), .ser_dout(ser_dout), .codes(codes));

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    ser_din = b;
    ser_clk = 1'b1;
    wait_cyc(PH);
    ser_clk = 1'b0;
    wait_cyc(PH);
    if (!load_n) m_chain = {m_chain[L-2:0], b};
    chk("R7 ser_dout", ser_dout, m_chain[L-1]);
  endtask

  task automatic send_word(input int v);
    for (int b = W - 1; b >= 0; b--) send_bit(v[b]);
  endtask

  task automatic release_load();
    load_n = 1'b1;
    wait_cyc(PH);
    m_codes = m_chain;
  endtask

  task automatic check_codes(input string req);
    for (int c = 0; c < N; c++)
      chk(req, codes[c*W +: W], m_codes[c*W +: W]);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    int ref_ch3;
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(2);
    chk("R8 reset codes", codes, 0);
    chk("R8 reset ser_dout", ser_dout, 0);

    // R10 R5 R1: every value into every channel; channel c gets (v + 17c) mod 64
    for (int v = 0; v < 64; v++) begin
      load_n = 1'b0;
      wait_cyc(PH);
      for (int c = N - 1; c >= 0; c--) send_word((v + 17 * c) % 64);
      chk("R4 codes held during load", codes, m_codes);
      release_load();
      for (int c = 0; c < N; c++)
        chk("R1 R5 R10 channel code", codes[c*W +: W], (v + 17 * c) % 64);
    end

    // R3: edges with strobe high do nothing
    for (int i = 0; i < 2 * W; i++) send_bit(i[0]);
    load_n = 1'b0;
    wait_cyc(PH);
    release_load();
    check_codes("R3 no shift while high");

    // R6: partial load of two words
    ref_ch3 = m_chain[0 +: W];
    load_n = 1'b0;
    wait_cyc(PH);
    send_word(6'h2A);
    send_word(6'h15);
    release_load();
    chk("R6 channel1", codes[0 +: W], 6'h15);
    chk("R6 channel2", codes[W +: W], 6'h2A);
    chk("R6 channel3 from old chain", codes[2*W +: W], ref_ch3);
    check_codes("R6 partial load");

    // R9: clock falls in the same cycle as strobe release
    load_n = 1'b0;
    wait_cyc(PH);
    send_word(6'h3F);
    ser_din = 1'b0;
    ser_clk = 1'b1;
    wait_cyc(PH);
    ser_clk = 1'b0;
    load_n = 1'b1;
    wait_cyc(PH);
    m_codes = m_chain;
    check_codes("R9 coincident edge ignored");
    chk("R9 ser_dout", ser_dout, m_chain[L-1]);

    // R2: rising clock edge alone does not shift
    load_n = 1'b0;
    wait_cyc(PH);
    ser_din = ~m_chain[L-2];
    ser_clk = 1'b1;
    wait_cyc(2 * PH);
    chk("R2 rising edge no shift", ser_dout, m_chain[L-1]);
    ser_clk = 1'b0;
    wait_cyc(PH);
    m_chain = {m_chain[L-2:0], ser_din};
    chk("R2 falling edge shifts", ser_dout, m_chain[L-1]);

    // R8: reset in mid load clears chain
    rst = 1'b1;
    wait_cyc(2);
    rst = 1'b0;
    m_chain = '0;
    m_codes = '0;
    wait_cyc(2);
    chk("R8 reset codes mid load", codes, 0);
    chk("R8 reset ser_dout mid load", ser_dout, 0);
    load_n = 1'b1;
    wait_cyc(PH);
    load_n = 1'b0;
    wait_cyc(PH);
    release_load();
    chk("R8 chain cleared", codes, 0);

    done = 1;
    finish_run();
  end
endmodule